// File: doc/BRIEF.md
# Three-wire serial EEPROM device model

This block models the device side of a three-wire serial EEPROM bus: chip select, serial clock, serial data in and serial data out. It holds a small array of 16-bit words, preloaded at reset from a seed and a step, and is meant to sit opposite a bus master in a verification environment. All of its logic runs on one system clock. The serial clock is sampled, and every rising edge seen while chip select is high moves one command bit in and, in an output phase, one data bit out. The master keeps the serial clock slow compared with the system clock.

A command starts with a 1 start bit and carries a two-bit opcode and an address. Reads return a zero dummy bit and then the data, MSB first. Writes take the data after the address and are accepted only while a write-enable latch is set. The model then signals programming busy on the output for a fixed number of system clocks. A mode parameter selects word or byte organisation. In byte organisation the address has one more bit and 8 data bits move in or out.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, no programming is in progress, and word i of the array holds INIT_SEED XOR (i * INIT_STEP) truncated to 16 bits.
- R2: The decoder waits for a 1 on `di` at a rising serial-clock edge while `cs` is high. Zeros before it are ignored.
- R3: Opcode 2'b10 is a read. On the rising edge that clocks in the last address bit, `dout` goes to 0 (the dummy bit). Each of the next 16 edges presents the next data bit, MSB first.
- R4: With BYTE_MODE=1 the address is ADDR_W+1 bits wide. Byte address b refers to word b>>1, low byte when b[0]=0 and high byte when b[0]=1. Reads return 8 bits after the dummy 0.
- R5: Opcode 2'b00 with the top two address bits 2'b11 sets the write-enable latch, and with 2'b00 it clears it. A write received while the latch is clear changes no memory and shows no busy phase.
- R6: Opcode 2'b01 is a write: the address, then the data MSB first. With the latch set, the addressed location takes the data. While `cs` stays high, `dout` then reads 0 for exactly BUSY_CYC system clocks and 1 afterwards.
- R7: Dropping `cs` at any point abandons the command in progress. A write cut short changes no memory, and the next command decodes normally.
- R8: A programming cycle that has started completes even if `cs` drops during it.
- R9: `dout` is 1 whenever `cs` is low, and whenever `cs` is high outside a read output phase and a busy phase, including after the last data bit of a read.
- R10: In byte organisation a write changes only the addressed byte of its word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the master; rising edges shift bits |
| di | input | 1 | Serial command, address and write data from the master |
| dout | output | 1 | Serial read data, dummy bit, and busy/ready status |

## Verification
The bench reads every word and every byte of both organisations and checks the dummy bit on each read. A model that returns data one edge early fails with a shifted word, and a byte-lane mix-up shows as swapped bytes. It writes while the latch is clear and after it is cleared again, and counts the busy clocks exactly. A model that ignores the latch, or that is off by one in its busy timer, gives a wrong readback or a wrong count. It cuts a read and a write short by dropping chip select and drops chip select in the middle of programming. These catch a decoder that keeps partial state, a model that commits a truncated write, and one that throws away a programming cycle that has already started. The boundary addresses 0 and the top word are covered, along with the idle level after the last read bit.

// File: rtl/uwire_eeprom_pkg.sv
package uwire_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_OP   = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_READ = 3'd4,
        ST_DONE = 3'd5
    } ee_state_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    localparam logic [1:0] EXT_ENABLE  = 2'b11;
    localparam logic [1:0] EXT_DISABLE = 2'b00;

    localparam int WORD_W = 16;

endpackage

// File: rtl/uwire_eeprom_store.sv
module uwire_eeprom_store
    import uwire_eeprom_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] INIT_SEED = 16'h3C5A,
    parameter logic [15:0] INIT_STEP = 16'h0B17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        wr_mask
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int N_LANES = WORD_W / 8;

    function automatic logic [7:0] preload_byte(input int idx, input int lane);
        logic [WORD_W-1:0] w;
        w = INIT_SEED ^ WORD_W'(idx * int'(INIT_STEP));
        return w[lane*8 +: 8];
    endfunction

    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        logic [7:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) begin
                    lane_q[k] <= preload_byte(k, ln);
                end
            end else if (wr_en && wr_mask[ln]) begin
                lane_q[wr_idx] <= wr_data[ln*8 +: 8];
            end
        end

        assign rd_word[ln*8 +: 8] = lane_q[rd_idx];
    end

endmodule

// File: rtl/uwire_eeprom_timer.sv
module uwire_eeprom_timer #(
    parameter int BUSY_CYC = 40,
    parameter int CNT_W    = $clog2(BUSY_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [CNT_W-1:0] remain
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(BUSY_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy   = (cnt_q != '0);
    assign remain = cnt_q;

endmodule

// File: rtl/uwire_eeprom_fsm.sv
module uwire_eeprom_fsm
    import uwire_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter bit BYTE_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              busy,
    output logic [ADDR_W-1:0] rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic [1:0]        wr_mask,
    output logic              wen,
    output logic              dout_raw,
    output ee_state_e         state
);

    localparam int CMD_AW = ADDR_W + (BYTE_MODE ? 1 : 0);
    localparam int DATA_W = BYTE_MODE ? 8 : WORD_W;
    localparam int CNT_MX = (CMD_AW > DATA_W) ? CMD_AW : DATA_W;
    localparam int CNT_W  = $clog2(CNT_MX + 1);

    typedef struct packed {
        ee_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic [CMD_AW-1:0] addr;
        logic [DATA_W-1:0] din;
        logic [WORD_W-1:0] osr;
        logic              dout;
        logic              wen;
        logic              go;
        logic              sk_prev;
    } fsm_s;

    fsm_s q, d;

    logic              sk_rise;
    logic [CMD_AW-1:0] addr_nx;
    logic [WORD_W-1:0] load_val;

    assign sk_rise = sk && !q.sk_prev;
    assign addr_nx = {q.addr[CMD_AW-2:0], di};
    assign rd_idx  = addr_nx[CMD_AW-1 -: ADDR_W];
    assign wr_idx  = q.addr[CMD_AW-1 -: ADDR_W];

    if (BYTE_MODE) begin : g_byte
        assign load_val = addr_nx[0] ? {rd_word[15:8], 8'h00} : {rd_word[7:0], 8'h00};
        assign wr_data  = {q.din, q.din};
        assign wr_mask  = q.addr[0] ? 2'b10 : 2'b01;
    end else begin : g_word
        assign load_val = rd_word;
        assign wr_data  = q.din;
        assign wr_mask  = 2'b11;
    end

    always_comb begin
        d         = q;
        d.go      = 1'b0;
        d.sk_prev = sk;
        if (!cs) begin
            d.st   = ST_WAIT;
            d.cnt  = '0;
            d.dout = 1'b1;
        end else if (sk_rise) begin
            unique case (q.st)
                ST_WAIT: begin
                    if (di) begin
                        d.st  = ST_OP;
                        d.cnt = '0;
                    end
                end
                ST_OP: begin
                    d.op = {q.op[0], di};
                    if (q.cnt == CNT_W'(1)) begin
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_nx;
                    if (q.cnt == CNT_W'(CMD_AW - 1)) begin
                        d.cnt = '0;
                        d.st  = ST_DONE;
                        if (!busy) begin
                            unique case (q.op)
                                OPC_READ: begin
                                    d.st   = ST_READ;
                                    d.osr  = load_val;
                                    d.dout = 1'b0;
                                end
                                OPC_WRITE: d.st = ST_DATA;
                                OPC_EXT: begin
                                    if (addr_nx[CMD_AW-1 -: 2] == EXT_ENABLE) begin
                                        d.wen = 1'b1;
                                    end else if (addr_nx[CMD_AW-1 -: 2] == EXT_DISABLE) begin
                                        d.wen = 1'b0;
                                    end
                                end
                                default: d.st = ST_DONE;
                            endcase
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    d.din = {q.din[DATA_W-2:0], di};
                    if (q.cnt == CNT_W'(DATA_W - 1)) begin
                        d.st  = ST_DONE;
                        d.go  = q.wen && !busy;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (q.cnt == CNT_W'(DATA_W)) begin
                        d.dout = 1'b1;
                        d.st   = ST_DONE;
                    end else begin
                        d.dout = q.osr[WORD_W-1];
                        d.osr  = {q.osr[WORD_W-2:0], 1'b0};
                        d.cnt  = q.cnt + 1'b1;
                    end
                end
                default: d.st = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_WAIT;
            q.cnt     <= '0;
            q.op      <= '0;
            q.addr    <= '0;
            q.din     <= '0;
            q.osr     <= '0;
            q.dout    <= 1'b1;
            q.wen     <= 1'b0;
            q.go      <= 1'b0;
            q.sk_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wr_go    = q.go;
    assign wen      = q.wen;
    assign dout_raw = q.dout;
    assign state    = q.st;

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
    import uwire_eeprom_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter bit          BYTE_MODE = 1'b0,
    parameter int          BUSY_CYC  = 40,
    parameter logic [15:0] INIT_SEED = 16'h3C5A,
    parameter logic [15:0] INIT_STEP = 16'h0B17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);

    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    logic [ADDR_W-1:0] rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic [1:0]        wr_mask;
    logic              wen;
    logic              dout_raw;
    ee_state_e         state;
    logic              busy;
    logic [BUSY_W-1:0] busy_cnt;

    uwire_eeprom_fsm #(
        .ADDR_W    (ADDR_W),
        .BYTE_MODE (BYTE_MODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .sk       (sk),
        .di       (di),
        .busy     (busy),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word),
        .wr_go    (wr_go),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .wen      (wen),
        .dout_raw (dout_raw),
        .state    (state)
    );

    uwire_eeprom_store #(
        .ADDR_W    (ADDR_W),
        .INIT_SEED (INIT_SEED),
        .INIT_STEP (INIT_STEP)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_word (rd_word),
        .wr_en   (wr_go),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_mask (wr_mask)
    );

    uwire_eeprom_timer #(
        .BUSY_CYC (BUSY_CYC),
        .CNT_W    (BUSY_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_go),
        .busy   (busy),
        .remain (busy_cnt)
    );

    assign dout = cs ? (busy ? 1'b0 : dout_raw) : 1'b1;

endmodule

module uwire_eeprom_chk
    import uwire_eeprom_pkg::*;
#(
    parameter int BUSY_CYC = 40,
    parameter int BUSY_W   = $clog2(BUSY_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              dout,
    input ee_state_e         state,
    input logic              wr_go,
    input logic              busy,
    input logic [BUSY_W-1:0] busy_cnt
);

    // R7
    abort_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == ST_WAIT));

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> dout);

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state == ST_READ) && cs) |-> !dout);

    // R6
    go_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> busy);

    // R6
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BUSY_W'(BUSY_CYC));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt > BUSY_W'(1)) |=> busy);

endmodule

bind uwire_eeprom uwire_eeprom_chk #(
    .BUSY_CYC (BUSY_CYC),
    .BUSY_W   (BUSY_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .dout     (dout),
    .state    (state),
    .wr_go    (wr_go),
    .busy     (busy),
    .busy_cnt (busy_cnt)
);

// File: tb/sim_uwire_eeprom.sv
module sim_uwire_eeprom;

    localparam int          AW   = 6;
    localparam int          BUSY = 25;
    localparam logic [15:0] SEED = 16'h3C5A;
    localparam logic [15:0] STEP = 16'h0B17;
    localparam int          NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs0 = 1'b0;
    logic cs1 = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout0, dout1;

    always #5 clk = ~clk;

    uwire_eeprom #(.ADDR_W(AW), .BYTE_MODE(1'b0), .BUSY_CYC(BUSY),
                   .INIT_SEED(SEED), .INIT_STEP(STEP))
        u0 (.clk(clk), .rst_n(rst_n), .cs(cs0), .sk(sk), .di(di), .dout(dout0));

    uwire_eeprom #(.ADDR_W(AW), .BYTE_MODE(1'b1), .BUSY_CYC(BUSY),
                   .INIT_SEED(SEED), .INIT_STEP(STEP))
        u1 (.clk(clk), .rst_n(rst_n), .cs(cs1), .sk(sk), .di(di), .dout(dout1));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] shadow0 [NW];
    logic [15:0] shadow1 [NW];

    function automatic logic [15:0] preload(input int i);
        return SEED ^ 16'(i * int'(STEP));
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic cur_dout(input int dev);
        return (dev == 0) ? dout0 : dout1;
    endfunction

    task automatic set_cs(input int dev, input logic v);
        @(negedge clk);
        sk = 1'b0;
        if (dev == 0) cs0 = v; else cs1 = v;
        @(negedge clk);
    endtask

    task automatic pulse(input int dev, input logic b, output logic o);
        @(negedge clk);
        sk = 1'b0;
        di = b;
        repeat (2) @(negedge clk);
        sk = 1'b1;
        repeat (2) @(negedge clk);
        o = cur_dout(dev);
    endtask

    task automatic send(input int dev, input logic [1:0] op, input logic [8:0] a,
                        output logic last);
        int aw;
        logic o;
        aw = (dev == 0) ? AW : AW + 1;
        pulse(dev, 1'b1, o);
        pulse(dev, op[1], o);
        pulse(dev, op[0], o);
        for (int i = aw - 1; i >= 0; i--) pulse(dev, a[i], o);
        last = o;
    endtask

    task automatic read_item(input int dev, input logic [8:0] a,
                             output logic [15:0] data, output logic dummy);
        int dw;
        logic o;
        dw = (dev == 0) ? 16 : 8;
        data = '0;
        set_cs(dev, 1'b1);
        send(dev, 2'b10, a, dummy);
        for (int i = 0; i < dw; i++) begin
            pulse(dev, 1'b0, o);
            data = {data[14:0], o};
        end
        set_cs(dev, 1'b0);
    endtask

    task automatic write_item(input int dev, input logic [8:0] a,
                              input logic [15:0] v, output int busy_n);
        int dw;
        logic o;
        dw = (dev == 0) ? 16 : 8;
        set_cs(dev, 1'b1);
        send(dev, 2'b01, a, o);
        for (int i = dw - 1; i >= 0; i--) pulse(dev, v[i], o);
        busy_n = 0;
        while (cur_dout(dev) == 1'b0 && busy_n < 1000) begin
            busy_n++;
            @(negedge clk);
        end
        check("R6", 32'(cur_dout(dev)), 32'd1, "ready level after busy");
        set_cs(dev, 1'b0);
    endtask

    task automatic ext_cmd(input int dev, input logic en);
        int aw;
        logic [8:0] a;
        logic o;
        aw = (dev == 0) ? AW : AW + 1;
        a = en ? (9'b11 << (aw - 2)) : 9'd0;
        set_cs(dev, 1'b1);
        send(dev, 2'b00, a, o);
        set_cs(dev, 1'b0);
    endtask

    function automatic logic [7:0] exp_byte(input int b);
        logic [15:0] w;
        w = shadow1[b >> 1];
        return (b % 2 == 1) ? w[15:8] : w[7:0];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] data;
        logic        dummy;
        logic        o;
        int          bn;

        for (int i = 0; i < NW; i++) begin
            shadow0[i] = preload(i);
            shadow1[i] = preload(i);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: idle level after reset
        check("R9", 32'(dout0), 32'd1, "dout0 idle after reset");
        check("R9", 32'(dout1), 32'd1, "dout1 idle after reset");
        set_cs(0, 1'b1);
        repeat (3) @(negedge clk);
        check("R9", 32'(dout0), 32'd1, "dout0 selected idle");
        set_cs(0, 1'b0);

        // R1, R3: full word sweep with dummy bit
        for (int a = 0; a < NW; a++) begin
            read_item(0, 9'(a), data, dummy);
            check("R3", 32'(dummy), 32'd0, $sformatf("dummy bit word %0d", a));
            check("R1", 32'(data), 32'(shadow0[a]), $sformatf("preload word %0d", a));
        end

        // R4: full byte sweep
        for (int b = 0; b < 2 * NW; b++) begin
            read_item(1, 9'(b), data, dummy);
            check("R4", 32'(dummy), 32'd0, $sformatf("dummy bit byte %0d", b));
            check("R4", 32'(data[7:0]), 32'(exp_byte(b)), $sformatf("byte %0d", b));
        end

        // R2: leading zeros before the start bit
        set_cs(0, 1'b1);
        for (int i = 0; i < 3; i++) pulse(0, 1'b0, o);
        send(0, 2'b10, 9'd5, dummy);
        data = '0;
        for (int i = 0; i < 16; i++) begin
            pulse(0, 1'b0, o);
            data = {data[14:0], o};
        end
        set_cs(0, 1'b0);
        check("R2", 32'(dummy), 32'd0, "dummy after leading zeros");
        check("R2", 32'(data), 32'(shadow0[5]), "read after leading zeros");

        // R5: write with latch clear after reset is ignored
        write_item(0, 9'd9, 16'h1234, bn);
        check("R5", 32'(bn), 32'd0, "no busy with latch clear");
        read_item(0, 9'd9, data, dummy);
        check("R5", 32'(data), 32'(shadow0[9]), "memory kept with latch clear");

        // R6: enable, write, exact busy length
        ext_cmd(0, 1'b1);
        write_item(0, 9'd9, 16'hBEEF, bn);
        shadow0[9] = 16'hBEEF;
        check("R6", 32'(bn), 32'(BUSY), "busy clocks word 9");
        read_item(0, 9'd9, data, dummy);
        check("R6", 32'(data), 32'hBEEF, "readback word 9");

        write_item(0, 9'(NW - 1), 16'h0001, bn);
        shadow0[NW-1] = 16'h0001;
        check("R6", 32'(bn), 32'(BUSY), "busy clocks top word");
        write_item(0, 9'd0, 16'hFFFF, bn);
        shadow0[0] = 16'hFFFF;
        read_item(0, 9'(NW - 1), data, dummy);
        check("R6", 32'(data), 32'h0001, "readback top word");
        read_item(0, 9'd0, data, dummy);
        check("R6", 32'(data), 32'hFFFF, "readback word 0");

        // R7: abort a read in the address phase
        set_cs(0, 1'b1);
        pulse(0, 1'b1, o);
        pulse(0, 1'b1, o);
        pulse(0, 1'b0, o);
        for (int i = 0; i < 3; i++) pulse(0, 1'b1, o);
        set_cs(0, 1'b0);
        read_item(0, 9'd10, data, dummy);
        check("R7", 32'(data), 32'(shadow0[10]), "read after aborted read");

        // R7: abort a write in the data phase
        set_cs(0, 1'b1);
        send(0, 2'b01, 9'd12, o);
        for (int i = 0; i < 10; i++) pulse(0, 1'b1, o);
        set_cs(0, 1'b0);
        set_cs(0, 1'b1);
        repeat (3) @(negedge clk);
        check("R7", 32'(dout0), 32'd1, "no busy after truncated write");
        set_cs(0, 1'b0);
        read_item(0, 9'd12, data, dummy);
        check("R7", 32'(data), 32'(shadow0[12]), "memory kept after truncated write");

        // R8: chip select dropped during programming
        set_cs(0, 1'b1);
        send(0, 2'b01, 9'd20, o);
        for (int i = 15; i >= 0; i--) pulse(0, logic'((16'h5A5A >> i) & 1), o);
        set_cs(0, 1'b0);
        check("R9", 32'(dout0), 32'd1, "dout high with cs low while programming");
        shadow0[20] = 16'h5A5A;
        repeat (BUSY + 5) @(negedge clk);
        read_item(0, 9'd20, data, dummy);
        check("R8", 32'(data), 32'h5A5A, "write completes after cs drop");

        // R9: extra clock after the last read bit
        set_cs(0, 1'b1);
        send(0, 2'b10, 9'd0, dummy);
        for (int i = 0; i < 16; i++) pulse(0, 1'b0, o);
        pulse(0, 1'b0, o);
        check("R9", 32'(o), 32'd1, "dout after read completes");
        set_cs(0, 1'b0);

        // R5: disable clears the latch
        ext_cmd(0, 1'b0);
        write_item(0, 9'd9, 16'h0000, bn);
        check("R5", 32'(bn), 32'd0, "no busy after disable");
        read_item(0, 9'd9, data, dummy);
        check("R5", 32'(data), 32'hBEEF, "memory kept after disable");

        // R10: byte write touches one lane only
        ext_cmd(1, 1'b1);
        write_item(1, 9'd7, 16'h009C, bn);
        shadow1[3][15:8] = 8'h9C;
        check("R6", 32'(bn), 32'(BUSY), "busy clocks byte write");
        read_item(1, 9'd7, data, dummy);
        check("R10", 32'(data[7:0]), 32'h9C, "written high byte");
        read_item(1, 9'd6, data, dummy);
        check("R10", 32'(data[7:0]), 32'(exp_byte(6)), "neighbour low byte kept");
        write_item(1, 9'd0, 16'h0042, bn);
        shadow1[0][7:0] = 8'h42;
        read_item(1, 9'd0, data, dummy);
        check("R10", 32'(data[7:0]), 32'h42, "written low byte 0");
        read_item(1, 9'd1, data, dummy);
        check("R10", 32'(data[7:0]), 32'(exp_byte(1)), "neighbour high byte kept");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule